// File: doc/BRIEF.md
# Command/Response Bus Controller Retry and Timeout Sequencer

This block runs the per-message response phase of a bus controller that drives two redundant buses (bus 0 and bus 1). Message setup is latched from a start strobe: the requested bus, a two-bit retry policy, a global and a local retry enable, and a two-bit no-response timeout select. The block then issues a transmit request for the first attempt and waits for the decoder. The decoder either reports a valid response or flags an error. If neither happens, the selected timeout expires.

A failed attempt, whether by timeout or by error, leads to one of two outcomes. If the policy and the enables allow another attempt, the block issues a new transmit request on the bus the policy chooses. Otherwise it ends the message with a failure status. A message that succeeds after at least one retry can optionally move the default bus to the bus that carried the successful attempt. Word encoding, word decoding and message-list fetching are handled by neighbouring blocks.

Top module: `bc_retry_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after release, every strobe output is low. In that state `busy`, `cmp_ok`, `cmp_bus`, `cmp_att` and `def_bus` are all 0.
- R2: A `msg_start` seen while idle produces a one-cycle `tx_req` in the next cycle, with `tx_bus` equal to the sampled `msg_bus`.
- R3: The timeout select codes map as follows: 00 gives 14 us, 01 gives 18 us, 10 gives 26 us and 11 gives 42 us. With TICKS_PER_US clock cycles per microsecond, `evt_timeout` pulses exactly N*TICKS_PER_US cycles after the `tx_req` cycle of the attempt, when nothing was received.
- R4: A retry is permitted only if `glb_retry_en` or `loc_retry_en` was high at start. With both low, a message makes exactly one attempt whatever the policy.
- R5: The retry policy codes define the attempt sequence, where b is the starting bus:
  - 00 (no retry): one attempt on b.
  - 01 (same bus): attempts on b, b.
  - 10 (alternate bus): attempts on b, ~b.
  - 11 (alternate then original): attempts on b, ~b, b.
- R6: Every retry issues `tx_req` together with a one-cycle `evt_retry`. The timeout of the new attempt is counted afresh from that `tx_req`.
- R7: An `rsp_err` during an attempt fails that attempt, and `evt_error` pulses in the next cycle. `rsp_err` takes priority over a simultaneous `rsp_ok` and over a simultaneous expiry. `evt_timeout` and `evt_error` never pulse together.
- R8: An `rsp_ok` without `rsp_err` ends the message in the next cycle with `evt_eom`=1 and `cmp_ok`=1. In that cycle `cmp_bus` holds the bus of the attempt and `cmp_att` holds its zero-based index. These completion fields hold until the next completion.
- R9: When the last permitted attempt fails, `evt_eom` pulses with `cmp_ok`=0, and `cmp_bus`/`cmp_att` give the bus and index of that last attempt. No further `tx_req` is issued.
- R10: With `bus_sw_en` high, a success on an attempt with index greater than 0 sets `def_bus` to that attempt's bus in the `evt_eom` cycle. A success on the first attempt, or any completion with `bus_sw_en` low, leaves `def_bus` unchanged.
- R11: `msg_start` while busy is ignored: it produces no `tx_req`, does not restart the timer and does not change the active bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Start strobe for a message |
| msg_bus | input | 1 | Bus for the first attempt |
| retry_pol | input | 2 | Retry policy code (R5) |
| glb_retry_en | input | 1 | Global retry enable |
| loc_retry_en | input | 1 | Per-message retry enable |
| tmo_sel | input | 2 | Response timeout select (R3) |
| bus_sw_en | input | 1 | Enable default-bus switch after a successful retry |
| rsp_ok | input | 1 | Decoder: valid response received |
| rsp_err | input | 1 | Decoder: response error |
| tx_req | output | 1 | Transmit request strobe |
| tx_bus | output | 1 | Bus for the current attempt |
| evt_timeout | output | 1 | No-response timeout event |
| evt_error | output | 1 | Message error event |
| evt_retry | output | 1 | Retry event |
| evt_eom | output | 1 | End-of-message event |
| cmp_ok | output | 1 | Completion status: success |
| cmp_bus | output | 1 | Completion status: bus of the final attempt |
| cmp_att | output | 2 | Completion status: index of the final attempt |
| def_bus | output | 1 | Default bus for later messages |
| busy | output | 1 | A message is in progress |

## Verification
The bench sweeps every policy, both enables, every timeout code and both starting buses, and measures each timeout latency to the cycle. A timer that is not cleared per attempt, or that is off by one, shows up as a wrong latency on the second or third attempt. The third attempt of policy 11 must return to the original bus; a design that keeps alternating, or stops after two attempts, fails there. Error and response arriving in the same cycle must count as an error, so a design that favours the response reports success instead. A start pulse in mid-message must be ignored, so a design that honours it restarts the timer or changes the bus. The default-bus switch is checked after successes on first, second and third attempts, with the switch enabled and disabled.

// File: rtl/bcrs_pkg.sv
package bcrs_pkg;
  typedef enum logic [1:0] {
    POL_NONE     = 2'b00,
    POL_SAME     = 2'b01,
    POL_ALT      = 2'b10,
    POL_ALT_SAME = 2'b11
  } rpol_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_st_e;

  localparam int unsigned MAX_TMO_US = 42;
  localparam int unsigned ATT_W      = 2;

  // Response window in microseconds for each select code.
  function automatic int unsigned tmo_us(input logic [1:0] sel);
    case (sel)
      2'b00:   tmo_us = 14;
      2'b01:   tmo_us = 18;
      2'b10:   tmo_us = 26;
      default: tmo_us = 42;
    endcase
  endfunction
endpackage

// File: rtl/bcrs_timer.sv
module bcrs_timer
  import bcrs_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 20,
  localparam int unsigned CW = $clog2(MAX_TMO_US * TICKS_PER_US + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       expired
);
  logic [CW-1:0] cnt_q, cnt_d, lim_m1;

  always_comb begin
    lim_m1  = CW'(tmo_us(sel) * TICKS_PER_US - 1);
    expired = run && (cnt_q == lim_m1);
    cnt_d   = cnt_q;
    if (restart)                cnt_d = '0;
    else if (run && !expired)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= lim_m1));
endmodule

// File: rtl/bcrs_plan.sv
module bcrs_plan
  import bcrs_pkg::*;
(
  input  rpol_e            pol,
  input  logic             rty_en,
  input  logic [ATT_W-1:0] att,
  input  logic             obus,
  output logic             more,
  output logic             nbus
);
  logic [ATT_W:0] total;

  always_comb begin
    if (!rty_en)                  total = 3'd1;
    else begin
      case (pol)
        POL_NONE:     total = 3'd1;
        POL_ALT_SAME: total = 3'd3;
        default:      total = 3'd2;
      endcase
    end
    more = ({1'b0, att} + 3'd1) < total;
    case (pol)
      POL_ALT:      nbus = ~obus;
      POL_ALT_SAME: nbus = (att == '0) ? ~obus : obus;
      default:      nbus = obus;
    endcase
  end
endmodule

// File: rtl/bcrs_ctrl.sv
module bcrs_ctrl
  import bcrs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_start,
  input  logic             msg_bus,
  input  logic [1:0]       pol_in,
  input  logic             glb_en,
  input  logic             loc_en,
  input  logic [1:0]       sel_in,
  input  logic             bus_sw_en,
  input  logic             rsp_ok,
  input  logic             rsp_err,
  input  logic             expired,
  input  logic             more,
  input  logic             nbus,
  output rpol_e            pol_q,
  output logic             rty_q,
  output logic [ATT_W-1:0] att_q,
  output logic             obus_q,
  output logic [1:0]       sel_q,
  output logic             tmr_restart,
  output logic             tmr_run,
  output logic             tx_req,
  output logic             tx_bus,
  output logic             evt_timeout,
  output logic             evt_error,
  output logic             evt_retry,
  output logic             evt_eom,
  output logic             cmp_ok,
  output logic             cmp_bus,
  output logic [ATT_W-1:0] cmp_att,
  output logic             def_bus,
  output logic             busy
);
  seq_st_e          st_q, st_d;
  rpol_e            pol_d;
  logic             rty_d, obus_d, cbus_q, cbus_d;
  logic [ATT_W-1:0] att_d, catt_q, catt_d;
  logic [1:0]       sel_d;
  logic             txr_q, txr_d, tmo_q, tmo_d, err_q, err_d, rty_ev_q, rty_ev_d;
  logic             eom_q, eom_d, cok_q, cok_d, cmpb_q, cmpb_d, dbus_q, dbus_d;
  logic             fail;

  always_comb begin
    st_d = st_q;   pol_d = pol_q;  rty_d = rty_q;  obus_d = obus_q;
    cbus_d = cbus_q; att_d = att_q; sel_d = sel_q; catt_d = catt_q;
    cok_d = cok_q; cmpb_d = cmpb_q; dbus_d = dbus_q;
    txr_d = 1'b0; tmo_d = 1'b0; err_d = 1'b0; rty_ev_d = 1'b0; eom_d = 1'b0;
    fail = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (msg_start) begin
          st_d   = ST_WAIT;
          txr_d  = 1'b1;
          cbus_d = msg_bus;
          obus_d = msg_bus;
          att_d  = '0;
          pol_d  = rpol_e'(pol_in);
          rty_d  = glb_en | loc_en;
          sel_d  = sel_in;
        end
      end
      default: begin
        fail = rsp_err | (expired & ~rsp_ok);
        if (rsp_err)                    err_d = 1'b1;
        else if (expired && !rsp_ok)    tmo_d = 1'b1;
        if (rsp_ok && !rsp_err) begin
          st_d   = ST_IDLE;
          eom_d  = 1'b1;
          cok_d  = 1'b1;
          cmpb_d = cbus_q;
          catt_d = att_q;
          if (bus_sw_en && (att_q != '0)) dbus_d = cbus_q;
        end else if (fail) begin
          if (more) begin
            txr_d    = 1'b1;
            rty_ev_d = 1'b1;
            cbus_d   = nbus;
            att_d    = att_q + 1'b1;
          end else begin
            st_d   = ST_IDLE;
            eom_d  = 1'b1;
            cok_d  = 1'b0;
            cmpb_d = cbus_q;
            catt_d = att_q;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  pol_q <= POL_NONE; rty_q <= 1'b0; obus_q <= 1'b0;
      cbus_q <= 1'b0;   att_q <= '0;       sel_q <= '0;   catt_q <= '0;
      cok_q <= 1'b0;    cmpb_q <= 1'b0;    dbus_q <= 1'b0;
      txr_q <= 1'b0;    tmo_q <= 1'b0;     err_q <= 1'b0;
      rty_ev_q <= 1'b0; eom_q <= 1'b0;
    end else begin
      st_q <= st_d;     pol_q <= pol_d;    rty_q <= rty_d; obus_q <= obus_d;
      cbus_q <= cbus_d; att_q <= att_d;    sel_q <= sel_d; catt_q <= catt_d;
      cok_q <= cok_d;   cmpb_q <= cmpb_d;  dbus_q <= dbus_d;
      txr_q <= txr_d;   tmo_q <= tmo_d;    err_q <= err_d;
      rty_ev_q <= rty_ev_d; eom_q <= eom_d;
    end
  end

  assign tmr_restart = txr_d;
  assign tmr_run     = (st_q == ST_WAIT);
  assign tx_req      = txr_q;
  assign tx_bus      = cbus_q;
  assign evt_timeout = tmo_q;
  assign evt_error   = err_q;
  assign evt_retry   = rty_ev_q;
  assign evt_eom     = eom_q;
  assign cmp_ok      = cok_q;
  assign cmp_bus     = cmpb_q;
  assign cmp_att     = catt_q;
  assign def_bus     = dbus_q;
  assign busy        = (st_q == ST_WAIT);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && msg_start) |=> (tx_req && tx_bus == $past(msg_bus)));
  // R5
  att_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= 2'd2);
  // R7
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_timeout && evt_error));
  // R8
  ok_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_eom && cmp_ok) |-> (!tx_req && !evt_retry && !busy));
  // R9
  fail_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_eom && !cmp_ok) |-> ((evt_timeout || evt_error) && !tx_req));
  // R10
  defbus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (def_bus != $past(def_bus)) |-> (evt_eom && cmp_ok && cmp_att != 2'd0));
endmodule

// File: rtl/bc_retry_seq.sv
module bc_retry_seq
  import bcrs_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       msg_start,
  input  logic       msg_bus,
  input  logic [1:0] retry_pol,
  input  logic       glb_retry_en,
  input  logic       loc_retry_en,
  input  logic [1:0] tmo_sel,
  input  logic       bus_sw_en,
  input  logic       rsp_ok,
  input  logic       rsp_err,
  output logic       tx_req,
  output logic       tx_bus,
  output logic       evt_timeout,
  output logic       evt_error,
  output logic       evt_retry,
  output logic       evt_eom,
  output logic       cmp_ok,
  output logic       cmp_bus,
  output logic [1:0] cmp_att,
  output logic       def_bus,
  output logic       busy
);
  rpol_e            pol_q;
  logic             rty_q, obus_q, more, nbus, expired, tmr_restart, tmr_run;
  logic [ATT_W-1:0] att_q;
  logic [1:0]       sel_q;

  bcrs_timer #(.TICKS_PER_US(TICKS_PER_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart), .run(tmr_run),
    .sel(sel_q), .expired(expired)
  );

  bcrs_plan u_plan (
    .pol(pol_q), .rty_en(rty_q), .att(att_q), .obus(obus_q),
    .more(more), .nbus(nbus)
  );

  bcrs_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_bus(msg_bus),
    .pol_in(retry_pol), .glb_en(glb_retry_en), .loc_en(loc_retry_en),
    .sel_in(tmo_sel), .bus_sw_en(bus_sw_en), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .expired(expired), .more(more), .nbus(nbus),
    .pol_q(pol_q), .rty_q(rty_q), .att_q(att_q), .obus_q(obus_q), .sel_q(sel_q),
    .tmr_restart(tmr_restart), .tmr_run(tmr_run),
    .tx_req(tx_req), .tx_bus(tx_bus), .evt_timeout(evt_timeout),
    .evt_error(evt_error), .evt_retry(evt_retry), .evt_eom(evt_eom),
    .cmp_ok(cmp_ok), .cmp_bus(cmp_bus), .cmp_att(cmp_att),
    .def_bus(def_bus), .busy(busy)
  );
endmodule

// File: tb/bc_retry_seq_test.sv
`timescale 1ns/1ps
module bc_retry_seq_test;
  localparam int TPU = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic msg_start, msg_bus, glb_retry_en, loc_retry_en, bus_sw_en, rsp_ok, rsp_err;
  logic [1:0] retry_pol, tmo_sel;
  logic tx_req, tx_bus, evt_timeout, evt_error, evt_retry, evt_eom;
  logic cmp_ok, cmp_bus, def_bus, busy;
  logic [1:0] cmp_att;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int mdb = 0;

  always #4 clk = ~clk;

  bc_retry_seq #(.TICKS_PER_US(TPU)) uut (
    .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_bus(msg_bus),
    .retry_pol(retry_pol), .glb_retry_en(glb_retry_en), .loc_retry_en(loc_retry_en),
    .tmo_sel(tmo_sel), .bus_sw_en(bus_sw_en), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
    .tx_req(tx_req), .tx_bus(tx_bus), .evt_timeout(evt_timeout), .evt_error(evt_error),
    .evt_retry(evt_retry), .evt_eom(evt_eom), .cmp_ok(cmp_ok), .cmp_bus(cmp_bus),
    .cmp_att(cmp_att), .def_bus(def_bus), .busy(busy)
  );

  task automatic chk(input bit c, input string req, input int act, input int exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int lim_of(input int sel);
    case (sel)
      0: lim_of = 14 * TPU;
      1: lim_of = 18 * TPU;
      2: lim_of = 26 * TPU;
      default: lim_of = 42 * TPU;
    endcase
  endfunction

  function automatic int total_of(input int pol, input int g, input int l);
    if (g == 0 && l == 0) total_of = 1;
    else if (pol == 0) total_of = 1;
    else if (pol == 3) total_of = 3;
    else total_of = 2;
  endfunction

  function automatic int bus_of(input int pol, input int a, input int b);
    if (a == 0) bus_of = b;
    else if (pol == 1) bus_of = b;
    else if (pol == 2) bus_of = 1 - b;
    else bus_of = (a == 1) ? 1 - b : b;
  endfunction

  task automatic run_msg(input int pol, input int g, input int l, input int sel,
                         input int b, input int err_mode, input int ok_att,
                         input int sw, input int both);
    int tot, eb, n;
    tot = total_of(pol, g, l);
    @(negedge clk);
    retry_pol = pol[1:0]; glb_retry_en = g[0]; loc_retry_en = l[0];
    tmo_sel = sel[1:0]; msg_bus = b[0]; bus_sw_en = sw[0]; msg_start = 1'b1;
    @(negedge clk);
    msg_start = 1'b0;
    for (int a = 0; a < tot; a++) begin
      eb = bus_of(pol, a, b);
      chk(tx_req == 1'b1, (a == 0) ? "R2" : "R6", int'(tx_req), 1);
      chk(tx_bus == eb[0], "R5", int'(tx_bus), eb);
      if (a == ok_att) begin
        repeat (3) @(negedge clk);
        rsp_ok = 1'b1;
        @(negedge clk);
        rsp_ok = 1'b0;
        chk(evt_eom && cmp_ok, "R8", int'({evt_eom, cmp_ok}), 3);
        chk(cmp_bus == eb[0], "R8", int'(cmp_bus), eb);
        chk(cmp_att == a[1:0], "R8", int'(cmp_att), a);
        if (sw != 0 && a != 0) mdb = eb;
        chk(def_bus == mdb[0], "R10", int'(def_bus), mdb);
        return;
      end
      if (err_mode != 0) begin
        repeat (2) @(negedge clk);
        rsp_err = 1'b1;
        if (both != 0) rsp_ok = 1'b1;
        @(negedge clk);
        rsp_err = 1'b0; rsp_ok = 1'b0;
        chk(evt_error && !evt_timeout, "R7", int'({evt_error, evt_timeout}), 2);
      end else begin
        n = 0;
        do begin
          @(negedge clk);
          n++;
        end while (!evt_timeout && n < 400);
        chk(n == lim_of(sel), (a == 0) ? "R3" : "R6", n, lim_of(sel));
      end
      if (a < tot - 1) begin
        chk(evt_retry == 1'b1 && evt_eom == 1'b0, "R6", int'({evt_retry, evt_eom}), 2);
      end else begin
        chk(evt_eom && !cmp_ok && !tx_req && !evt_retry, (tot == 1 && pol != 0) ? "R4" : "R9",
            int'({evt_eom, cmp_ok, tx_req, evt_retry}), 8);
        chk(cmp_bus == eb[0], "R9", int'(cmp_bus), eb);
        chk(cmp_att == a[1:0], "R9", int'(cmp_att), a);
        chk(def_bus == mdb[0], "R10", int'(def_bus), mdb);
      end
    end
    @(negedge clk);
    chk(busy == 1'b0 && tx_req == 1'b0, "R9", int'({busy, tx_req}), 0);
  endtask

  initial begin
    int n;
    rst_n = 1'b0;
    msg_start = 0; msg_bus = 0; glb_retry_en = 0; loc_retry_en = 0; bus_sw_en = 0;
    rsp_ok = 0; rsp_err = 0; retry_pol = 0; tmo_sel = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({tx_req, evt_timeout, evt_error, evt_retry, evt_eom} == 0, "R1",
        int'({tx_req, evt_timeout, evt_error, evt_retry, evt_eom}), 0);
    chk({busy, cmp_ok, cmp_bus, cmp_att, def_bus} == 0, "R1",
        int'({busy, cmp_ok, cmp_bus, cmp_att, def_bus}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_req, busy, evt_eom, def_bus} == 0, "R1", int'({tx_req, busy, evt_eom, def_bus}), 0);

    // R3 R4 R5 R6 R9: full timeout sweep
    for (int p = 0; p < 4; p++)
      for (int g = 0; g < 2; g++)
        for (int l = 0; l < 2; l++)
          for (int s = 0; s < 4; s++)
            for (int b = 0; b < 2; b++)
              run_msg(p, g, l, s, b, 0, -1, 0, 0);

    // R7: decoder errors on every attempt
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 2; b++)
        run_msg(p, 1, 0, 0, b, 1, -1, 0, 0);

    // R7: error and response in the same cycle count as error
    run_msg(0, 0, 0, 0, 1, 1, -1, 0, 1);
    run_msg(3, 0, 1, 0, 0, 1, -1, 0, 1);

    // R8 R10: success on each attempt, switch on and off
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 3; k++)
        for (int sw = 0; sw < 2; sw++)
          for (int b = 0; b < 2; b++)
            run_msg(p, 0, 1, 1, b, 0, k, sw, 0);

    // R11: start while busy is ignored
    @(negedge clk);
    retry_pol = 0; glb_retry_en = 0; loc_retry_en = 0; tmo_sel = 0;
    msg_bus = mdb[0]; msg_start = 1;
    @(negedge clk);
    msg_start = 0;
    chk(tx_req == 1'b1, "R2", int'(tx_req), 1);
    n = 0;
    @(negedge clk); n++;
    msg_bus = ~mdb[0]; msg_start = 1;
    @(negedge clk); n++;
    msg_start = 0;
    chk(tx_req == 1'b0, "R11", int'(tx_req), 0);
    chk(tx_bus == mdb[0], "R11", int'(tx_bus), mdb);
    while (!evt_timeout && n < 400) begin
      @(negedge clk); n++;
    end
    chk(n == lim_of(0), "R11", n, lim_of(0));
    chk(evt_eom && !cmp_ok && cmp_bus == mdb[0], "R11", int'({evt_eom, cmp_ok, cmp_bus}), 4 + 2 * 0 + mdb);
    @(negedge clk);
    chk(busy == 1'b0, "R11", int'(busy), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule